// File: doc/BRIEF.md
# Port Speed Calendar Packer

This block turns a list of per-port speed codes into a packed calendar image and checks the bandwidth it asks for. After a start pulse, the ports arrive one per accepted cycle in ascending order, from port 0 up to the last port. Each 3-bit code is stored in its field of a bank of calendar words, ten ports to a word. At the same time the block converts the code to a rate in Mb/s and adds it to two running sums. One sum covers the front ports only. The other is a grand total, in which internal ports count at half their rate.

When the last port has been taken, the block raises done and holds it. While done is high it shows two error flags. The first says the front-port sum is above a target bandwidth set by a parameter. The second says the total is above the core capacity, which is one third of the core clock picked by a select input, or that the select picks no supported clock. A new start pulse clears everything and begins again, even in the middle of a run.

Top module: `port_speed_calendar`

## Requirements
- R1: Speed codes map to rates in Mb/s as follows: 0 gives 0, 1 gives 1000, 2 gives 2500, 3 gives 5000, 4 gives 10000, 5 gives 25000, 6 gives 500 and 7 gives 12500. For a front port, this rate is added to both the front sum and the total.
- R2: The code of port p (counted from 0 in arrival order) sits in `calWords` at bit p*3, which is field p mod 10 of 30-bit word p/10. A port with code 0 leaves its field at zero, and so does every field no port reaches.
- R3: Ports whose index is at or above FRONT_PORTS (default 65) are internal. Half of their rate goes into the total, and nothing goes into the front sum.
- R4: `clkSel`, sampled on the start cycle, selects the core capacity: 0 gives 83000, 1 gives 166000 and 2 gives 208000. Value 3 is unsupported and always raises `coreErr`.
- R5: `portErr` is 1 exactly when the front sum is strictly greater than TARGET_BW (default 129000).
- R6: `coreErr` is 1 exactly when the total is strictly greater than the selected capacity, or when the select is unsupported.
- R7: A start pulse clears all fields and both sums, drops done, and makes the next accepted port port 0. This also holds in the middle of a run.
- R8: `done` goes high in the cycle after the last port is accepted and stays high until the next start. Both error flags read 0 whenever done is low.
- R9: A cycle with `portValid` low is skipped without advancing the port count. `portValid` has no effect when no run is active, including after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the block and begins a new run |
| clkSel | input | 2 | Core clock select, sampled with start |
| portValid | input | 1 | Presents the next port's code |
| portCode | input | 3 | Speed code of the presented port |
| done | output | 1 | All ports taken, results valid |
| portErr | output | 1 | Front-port bandwidth above target |
| coreErr | output | 1 | Total bandwidth above core capacity |
| calWords | output | 210 | Seven packed 30-bit calendar words, word 0 in the low bits |

## Verification
The assertions assume that start is a single-cycle pulse given outside reset, and that clkSel is only sampled on that cycle. They also assume that once a run begins, ports are only offered in ascending order, with as many gaps as the source likes. The bench keeps to this. It raises start for exactly one cycle, then drives one code per accepted cycle and sometimes inserts idle cycles with portValid low. It deliberately offers ports only before a run begins or after done, where they must be ignored. The sums are never brought out, so the bench computes them itself. It chooses patterns that land exactly on each limit and one step above it.

// File: rtl/pspc_pkg.sv
package pspc_pkg;

  localparam int CODE_W = 3;
  localparam int RATE_W = 15;
  localparam int CAP_W  = 18;

  typedef struct packed {
    logic clear;     // start of a new run
    logic accept;    // a port code is taken this cycle
    logic internal;  // the taken port is an internal one
  } strobe_t;

  function automatic logic [RATE_W-1:0] codeToRate(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return RATE_W'(1000);
      3'd2:    return RATE_W'(2500);
      3'd3:    return RATE_W'(5000);
      3'd4:    return RATE_W'(10000);
      3'd5:    return RATE_W'(25000);
      3'd6:    return RATE_W'(500);
      3'd7:    return RATE_W'(12500);
      default: return '0;
    endcase
  endfunction

  function automatic logic [CAP_W-1:0] selToCapacity(input logic [1:0] sel);
    case (sel)
      2'd0:    return CAP_W'(83000);
      2'd1:    return CAP_W'(166000);
      2'd2:    return CAP_W'(208000);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pspc_ctrl.sv
module pspc_ctrl
  import pspc_pkg::*;
#(
  parameter int NUM_PORTS      = 70,
  parameter int FRONT_PORTS    = 65,
  parameter int PORTS_PER_WORD = 10,
  parameter int NUM_WORDS      = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic portValid,
  output strobe_t strb,
  output logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] wordIdx,
  output logic [((PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1)-1:0] slotIdx,
  output logic done
);
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int SLOT_IDX_W = (PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t state;
  logic [PORT_IDX_W-1:0] portIdx;
  logic lastPort;
  logic lastSlot;
  logic lastAccept;

  assign lastPort   = (portIdx == PORT_IDX_W'(NUM_PORTS - 1));
  assign lastSlot   = (slotIdx == SLOT_IDX_W'(PORTS_PER_WORD - 1));
  assign lastAccept = strb.accept && lastPort;

  always_comb begin
    strb.clear    = start;
    strb.accept   = (state == S_RUN) && portValid && !start;
    strb.internal = (portIdx >= PORT_IDX_W'(FRONT_PORTS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      portIdx <= '0;
      wordIdx <= '0;
      slotIdx <= '0;
    end else if (start) begin
      state   <= S_RUN;
      portIdx <= '0;
      wordIdx <= '0;
      slotIdx <= '0;
    end else if (strb.accept) begin
      if (lastPort) begin
        state <= S_DONE;
      end
      portIdx <= portIdx + 1'b1;
      if (lastSlot) begin
        slotIdx <= '0;
        wordIdx <= wordIdx + 1'b1;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

  assign done = (state == S_DONE);

  // R8: done rises only right after the final port was taken
  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(lastAccept));

  // R7: a start pulse leaves done low and the port count at zero
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && portIdx == '0 && slotIdx == '0 && wordIdx == '0));

  // R9: without an accepted port the position does not move
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && !start) |=> ($stable(portIdx) && $stable(slotIdx)));

endmodule

// File: rtl/pspc_datapath.sv
module pspc_datapath
  import pspc_pkg::*;
#(
  parameter int NUM_PORTS      = 70,
  parameter int FRONT_PORTS    = 65,
  parameter int PORTS_PER_WORD = 10,
  parameter int NUM_WORDS      = 7,
  parameter int TARGET_BW      = 129000
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] wordIdx,
  input  logic [((PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1)-1:0] slotIdx,
  input  logic [CODE_W-1:0] portCode,
  input  logic [1:0] clkSel,
  input  logic done,
  output logic [NUM_WORDS*PORTS_PER_WORD*CODE_W-1:0] calWords,
  output logic portErr,
  output logic coreErr
);
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int SLOT_IDX_W = (PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1;
  localparam int SUM_W      = $clog2(NUM_PORTS * 25000 + 1);
  localparam int CMP_W      = (SUM_W > CAP_W) ? SUM_W : CAP_W;

  logic [SUM_W-1:0] frontSum;
  logic [SUM_W-1:0] totalSum;
  logic [CAP_W-1:0] capReg;
  logic             capBad;
  logic [RATE_W-1:0] rate;
  logic [RATE_W-1:0] weighted;

  assign rate     = codeToRate(portCode);
  assign weighted = strb.internal ? (rate >> 1) : rate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontSum <= '0;
      totalSum <= '0;
      capReg   <= '0;
      capBad   <= 1'b0;
    end else if (strb.clear) begin
      frontSum <= '0;
      totalSum <= '0;
      capReg   <= selToCapacity(clkSel);
      capBad   <= (clkSel == 2'd3);
    end else if (strb.accept) begin
      totalSum <= totalSum + SUM_W'(weighted);
      if (!strb.internal) begin
        frontSum <= frontSum + SUM_W'(rate);
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < PORTS_PER_WORD; s++) begin : g_slot
      localparam int FLAT = w * PORTS_PER_WORD + s;
      if (FLAT < NUM_PORTS) begin : g_used
        logic [CODE_W-1:0] field;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            field <= '0;
          end else if (strb.clear) begin
            field <= '0;
          end else if (strb.accept && wordIdx == WORD_IDX_W'(w)
                       && slotIdx == SLOT_IDX_W'(s)) begin
            field <= portCode;
          end
        end
        assign calWords[FLAT*CODE_W +: CODE_W] = field;
      end else begin : g_spare
        assign calWords[FLAT*CODE_W +: CODE_W] = '0;
      end
    end
  end

  assign portErr = done && (CMP_W'(frontSum) > CMP_W'(TARGET_BW));
  assign coreErr = done && (capBad || (CMP_W'(totalSum) > CMP_W'(capReg)));

  // R3: the front sum can never pass the total, since the total contains it
  p_front_within_total_r3: assert property (@(posedge clk) disable iff (!rstN)
    frontSum <= totalSum);

  // R1: taking a port never lowers the total
  p_total_grows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !strb.clear) |=> (totalSum >= $past(totalSum)));

  // R7: a start empties both sums
  p_sums_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (totalSum == '0 && frontSum == '0));

  // R4: the selected capacity holds still between starts
  p_cap_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> ($stable(capReg) && $stable(capBad)));

  // R8: no flag shows while results are not ready
  p_flags_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!portErr && !coreErr));

endmodule

// File: rtl/port_speed_calendar.sv
module port_speed_calendar
  import pspc_pkg::*;
#(
  parameter int NUM_PORTS      = 70,
  parameter int FRONT_PORTS    = 65,
  parameter int PORTS_PER_WORD = 10,
  parameter int TARGET_BW      = 129000,
  localparam int NUM_WORDS     = (NUM_PORTS + PORTS_PER_WORD - 1) / PORTS_PER_WORD,
  localparam int OUT_W         = NUM_WORDS * PORTS_PER_WORD * CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       clkSel,
  input  logic             portValid,
  input  logic [2:0]       portCode,
  output logic             done,
  output logic             portErr,
  output logic             coreErr,
  output logic [OUT_W-1:0] calWords
);
  localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int SLOT_IDX_W = (PORTS_PER_WORD > 1) ? $clog2(PORTS_PER_WORD) : 1;

  strobe_t strb;
  logic [WORD_IDX_W-1:0] wordIdx;
  logic [SLOT_IDX_W-1:0] slotIdx;

  pspc_ctrl #(
    .NUM_PORTS(NUM_PORTS), .FRONT_PORTS(FRONT_PORTS),
    .PORTS_PER_WORD(PORTS_PER_WORD), .NUM_WORDS(NUM_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .portValid(portValid),
    .strb(strb), .wordIdx(wordIdx), .slotIdx(slotIdx), .done(done)
  );

  pspc_datapath #(
    .NUM_PORTS(NUM_PORTS), .FRONT_PORTS(FRONT_PORTS),
    .PORTS_PER_WORD(PORTS_PER_WORD), .NUM_WORDS(NUM_WORDS),
    .TARGET_BW(TARGET_BW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx),
    .slotIdx(slotIdx), .portCode(portCode), .clkSel(clkSel),
    .done(done), .calWords(calWords), .portErr(portErr), .coreErr(coreErr)
  );

endmodule

// File: tb/port_speed_calendar_tb.sv
module port_speed_calendar_tb;
  localparam int NP     = 70;
  localparam int NF     = 65;
  localparam int TGT    = 129000;
  localparam int OUT_W  = 210;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] clkSel = 2'd0;
  logic portValid = 1'b0;
  logic [2:0] portCode = 3'd0;
  logic done, portErr, coreErr;
  logic [OUT_W-1:0] calWords;

  int errors = 0;
  int checks = 0;
  logic [2:0] codes [NP];
  bit gapsOn = 1'b0;

  always #5 clk = ~clk;

  port_speed_calendar #(.NUM_PORTS(NP), .FRONT_PORTS(NF), .TARGET_BW(TGT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .clkSel(clkSel),
    .portValid(portValid), .portCode(portCode), .done(done),
    .portErr(portErr), .coreErr(coreErr), .calWords(calWords)
  );

  function automatic int rateOf(input logic [2:0] c);
    case (c)
      3'd1: return 1000;   3'd2: return 2500;  3'd3: return 5000;
      3'd4: return 10000;  3'd5: return 25000; 3'd6: return 500;
      3'd7: return 12500;  default: return 0;
    endcase
  endfunction

  function automatic int capOf(input logic [1:0] s);
    case (s)
      2'd0: return 83000; 2'd1: return 166000; 2'd2: return 208000;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCodes();
    for (int p = 0; p < NP; p++) codes[p] = 3'd0;
  endtask

  task automatic pulseStart(input logic [1:0] sel);
    @(negedge clk);
    start = 1'b1; clkSel = sel; portValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Feeds all ports and checks the results against the arithmetic model.
  task automatic runAndCheck(input logic [1:0] sel, input string tag);
    int front, total;
    logic [OUT_W-1:0] expWords;
    bit expPort, expCore;
    front = 0; total = 0; expWords = '0;
    pulseStart(sel);
    for (int p = 0; p < NP; p++) begin
      if (gapsOn && ($urandom_range(0, 3) == 0)) begin
        portValid = 1'b0; portCode = 3'd7;
        @(negedge clk);
      end
      portValid = 1'b1; portCode = codes[p];
      if (p == NP - 1) begin
        // R8: done is still low while the last port is on offer
        chk(done == 1'b0, {tag, " R8 done early"}, 256'(done), 256'(0));
        // R8: flags stay low before done
        chk(!portErr && !coreErr, {tag, " R8 flags early"},
            256'({portErr, coreErr}), 256'(0));
      end
      @(negedge clk);
      expWords[p*3 +: 3] = codes[p];
      if (p < NF) begin
        front += rateOf(codes[p]);
        total += rateOf(codes[p]);
      end else begin
        total += rateOf(codes[p]) / 2;
      end
    end
    portValid = 1'b0;
    expPort = (front > TGT);
    expCore = (sel == 2'd3) || (total > capOf(sel));
    chk(done == 1'b1, {tag, " R8 done"}, 256'(done), 256'(1));
    chk(calWords == expWords, {tag, " R2 words"}, 256'(calWords), 256'(expWords));
    chk(portErr == expPort, {tag, " R5/R1/R3 portErr"}, 256'(portErr), 256'(expPort));
    chk(coreErr == expCore, {tag, " R6/R4/R3 coreErr"}, 256'(coreErr), 256'(expCore));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [OUT_W-1:0] held;
    clearCodes();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk(!done && !portErr && !coreErr && calWords == '0, "R8 reset state",
        256'({done, portErr, coreErr}), 256'(0));

    // R9: ports offered before any start are ignored
    portValid = 1'b1; portCode = 3'd5;
    repeat (4) @(negedge clk);
    portValid = 1'b0;
    chk(calWords == '0 && !done, "R9 ignored before start", 256'(calWords), 256'(0));

    // R1/R4: every code on every port, with each clock select
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int p = 0; p < NP; p++) codes[p] = 3'(c);
        runAndCheck(2'(s), "R1 uniform");
      end
    end

    // R2: distinct codes by position, code 0 on some fields
    for (int p = 0; p < NP; p++) codes[p] = 3'((p * 3 + 1) % 8);
    gapsOn = 1'b1;
    runAndCheck(2'd2, "R2 pattern gaps");

    // R5: front sum exactly at the target, then one step over
    clearCodes();
    for (int p = 0; p < 5; p++) codes[p] = 3'd5;
    for (int p = 5; p < 9; p++) codes[p] = 3'd1;
    runAndCheck(2'd2, "R5 at target");
    codes[20] = 3'd6;
    runAndCheck(2'd2, "R5 over target");

    // R6: total exactly at the 250 MHz capacity, then an internal port on top
    clearCodes();
    for (int p = 0; p < 3; p++) codes[p] = 3'd5;
    codes[3] = 3'd3; codes[4] = 3'd2; codes[5] = 3'd6;
    runAndCheck(2'd0, "R6 at capacity");
    codes[65] = 3'd7;
    runAndCheck(2'd0, "R3 internal half over cap");
    codes[65] = 3'd0; codes[66] = 3'd6; codes[67] = 3'd6;
    runAndCheck(2'd0, "R3 internal halves over cap");

    // R3: internal ports never count toward the front limit
    clearCodes();
    for (int p = 0; p < 5; p++) codes[p] = 3'd5;
    for (int p = 5; p < 9; p++) codes[p] = 3'd1;
    for (int p = NF; p < NP; p++) codes[p] = 3'd5;
    runAndCheck(2'd2, "R3 internal excluded");
    runAndCheck(2'd1, "R3 internal in total");

    // R4: unsupported select flags even an empty run
    clearCodes();
    runAndCheck(2'd3, "R4 bad select");

    // R9: input after done is ignored
    held = calWords;
    portValid = 1'b1; portCode = 3'd7;
    repeat (5) @(negedge clk);
    portValid = 1'b0;
    chk(calWords == held && done && coreErr, "R9 ignored after done",
        256'(calWords), 256'(held));

    // R7: restart in the middle of a run
    for (int p = 0; p < NP; p++) codes[p] = 3'd7;
    pulseStart(2'd0);
    for (int p = 0; p < 30; p++) begin
      portValid = 1'b1; portCode = 3'd5;
      @(negedge clk);
    end
    portValid = 1'b0;
    runAndCheck(2'd1, "R7 restart");

    // Random patterns with a spread of densities
    for (int r = 0; r < 40; r++) begin
      int dens;
      dens = $urandom_range(1, 8);
      for (int p = 0; p < NP; p++)
        codes[p] = ($urandom_range(0, 31) < dens) ? 3'($urandom_range(1, 7)) : 3'd0;
      runAndCheck(2'($urandom_range(0, 3)), "R1/R5/R6 random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule